// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block is the register-level control that sits between a host register bus and a keyed hash engine. It holds a small bank of 32-bit secrets in a one-time-programmable style store. Each secret has a lock bit that can only be set. Once a secret is locked, the bus can no longer see it or change it. The hash engine still receives it whenever the host selects it.

The host selects one secret as the hash function and one as the seed. Writing that selection pushes both values into the engine with a load pulse, which restores the original seed. The host then writes a 32-bit challenge, which starts a computation. It reads the 8-bit code once the engine reports completion.

A challenge is accepted only when a fresh selection has been written since the last accepted challenge. Any breach of this order, or any write to a locked secret, raises a sticky error flag in the status register. Reading the result too early returns the previous code and raises a not-ready flag.

Top module: `auth_seq_ctrl`

## Requirements
- R1: After reset, status, result, selection and lock bits read as zero, and neither hash_load nor hash_start is asserted.
- R2: A write to address 0x0 with function index in bits [1:0] and seed index in bits [3:2], both below the slot count, pulses hash_load for one cycle in the following cycle. During that pulse, hash_func and hash_seed carry the selected secrets. Both indices may name the same slot.
- R3: A challenge write to address 0x1, made after a fresh selection while no computation runs, pulses hash_start in the following cycle with the written word on hash_chal, and sets the busy bit (status bit 2).
- R4: A challenge write with no accepted selection since reset or since the last accepted challenge produces no hash_start and sets the error flag (status bit 0).
- R5: hash_done while busy stores hash_code into the result register (address 0x2, bits [7:0]) and clears busy.
- R6: A read of the result register while busy returns the previous code and sets the not-ready flag (status bit 1).
- R7: Status bits 0 and 1 stay set until the host writes a 1 to that bit at address 0x3. Writing 0 leaves them unchanged.
- R8: Writing 1s to the lock register (address 0x4, bit i for slot i) sets those lock bits. No bus write clears a lock bit.
- R9: Secret slot i sits at address 0x8+i. While its lock bit is clear it reads back what was written. While the lock bit is set, a read returns zero, and a write leaves the secret unchanged and sets the error flag.
- R10: A locked secret is still delivered to the hash engine through a selection, and it yields the same code as before it was locked.
- R11: A selection write with an index at or above the slot count is rejected: there is no hash_load pulse, the old selection is kept, and the error flag is set.
- R12: A selection write while busy is rejected with no hash_load pulse, and the error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| hash_load | output | 1 | One-cycle pulse: load function and seed into the engine |
| hash_func | output | 32 | Secret acting as the hash function |
| hash_seed | output | 32 | Secret acting as the initial seed |
| hash_start | output | 1 | One-cycle pulse: start a computation |
| hash_chal | output | 32 | Accepted challenge word |
| hash_done | input | 1 | Engine completion pulse |
| hash_code | input | 8 | Engine result, valid with hash_done |

## Verification
The bench sends a challenge with no fresh selection, both straight after reset and after a completed run. A design that accepted either one would pulse hash_start and reuse a stale seed. It reads the result and attempts a new selection while the engine is still counting. A wrong design would return a half-updated code, miss the not-ready flag, or reload the seed mid-run. It locks a slot, tries to clear the lock, reads the slot, and overwrites it. It then runs a computation through the locked slot, which catches a store that leaks, forgets locks, or lets a locked write corrupt the secret the engine uses. Out-of-range indices and write-zero on the sticky flags are also covered.

// File: rtl/auth_seq_pkg.sv
package auth_seq_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_SEL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_CHAL  = 4'h1;
  localparam logic [ADDR_W-1:0] A_RES   = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'h3;
  localparam logic [ADDR_W-1:0] A_LOCK  = 4'h4;
  localparam logic [ADDR_W-1:0] A_SLOT0 = 4'h8;

  localparam int ST_ERR  = 0;
  localparam int ST_NRDY = 1;
  localparam int ST_BUSY = 2;
endpackage

// File: rtl/auth_secret_store.sv
module auth_secret_store #(
  parameter int NSLOT  = 3,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         lock_en,
  input  logic [NSLOT-1:0]             lock_bits,
  output logic [NSLOT-1:0][DATA_W-1:0] slot_q,
  output logic [NSLOT-1:0]             lock_q,
  output logic                         wr_denied
);
  logic [NSLOT-1:0] lock_d;
  logic [NSLOT-1:0] hit;

  // Lock bits only ever accumulate.
  always_comb begin
    lock_d = lock_q;
    if (lock_en) lock_d = lock_q | lock_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  assign wr_denied = wr_en && |(hit & lock_q);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic en;
    assign hit[i] = (wr_idx == IDX_W'(i));
    assign en     = wr_en && hit[i] && !lock_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[i] <= '0;
      else if (en) slot_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/auth_seq_fsm.sv
module auth_seq_fsm #(
  parameter int NSLOT  = 3,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [IDX_W-1:0]  sel_f,
  input  logic [IDX_W-1:0]  sel_s,
  input  logic              chal_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              res_rd,
  input  logic              stat_wr,
  input  logic              slot_denied,
  input  logic              hash_done,
  input  logic [CODE_W-1:0] hash_code,
  output logic [IDX_W-1:0]  fidx_q,
  output logic [IDX_W-1:0]  sidx_q,
  output logic [DATA_W-1:0] chal_q,
  output logic [CODE_W-1:0] res_q,
  output logic              err_q,
  output logic              nrdy_q,
  output logic              busy_q,
  output logic              load_q,
  output logic              start_q
);
  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NSLOT - 1);

  logic              armed_q, armed_d;
  logic              busy_d, err_d, nrdy_d;
  logic              sel_ok, sel_bad, chal_ok, chal_bad;
  logic              clr_err, clr_nrdy, res_en;
  logic [IDX_W-1:0]  fidx_d, sidx_d;
  logic [DATA_W-1:0] chal_d;
  logic [CODE_W-1:0] res_d;

  always_comb begin
    sel_ok   = sel_wr && !busy_q && (sel_f <= MAX_IDX) && (sel_s <= MAX_IDX);
    sel_bad  = sel_wr && !sel_ok;
    chal_ok  = chal_wr && armed_q && !busy_q;
    chal_bad = chal_wr && !chal_ok;
    clr_err  = stat_wr && wdata[ST_ERR_BIT];
    clr_nrdy = stat_wr && wdata[ST_NRDY_BIT];
    res_en   = busy_q && hash_done;

    armed_d = armed_q;
    if (sel_ok)       armed_d = 1'b1;
    else if (chal_ok) armed_d = 1'b0;

    busy_d = busy_q;
    if (chal_ok)     busy_d = 1'b1;
    else if (res_en) busy_d = 1'b0;

    fidx_d = sel_ok  ? sel_f     : fidx_q;
    sidx_d = sel_ok  ? sel_s     : sidx_q;
    chal_d = chal_ok ? wdata     : chal_q;
    res_d  = res_en  ? hash_code : res_q;

    err_d  = (err_q && !clr_err) || sel_bad || chal_bad || slot_denied;
    nrdy_d = (nrdy_q && !clr_nrdy) || (res_rd && busy_q);
  end

  localparam int ST_ERR_BIT  = auth_seq_pkg::ST_ERR;
  localparam int ST_NRDY_BIT = auth_seq_pkg::ST_NRDY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      nrdy_q  <= 1'b0;
      load_q  <= 1'b0;
      start_q <= 1'b0;
      fidx_q  <= '0;
      sidx_q  <= '0;
      chal_q  <= '0;
      res_q   <= '0;
    end else begin
      armed_q <= armed_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      nrdy_q  <= nrdy_d;
      load_q  <= sel_ok;
      start_q <= chal_ok;
      fidx_q  <= fidx_d;
      sidx_q  <= sidx_d;
      chal_q  <= chal_d;
      res_q   <= res_d;
    end
  end
endmodule

// File: rtl/auth_seq_ctrl.sv
module auth_seq_ctrl
  import auth_seq_pkg::*;
#(
  parameter int NSLOT  = 3,
  parameter int DATA_W = 32,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              hash_load,
  output logic [DATA_W-1:0] hash_func,
  output logic [DATA_W-1:0] hash_seed,
  output logic              hash_start,
  output logic [DATA_W-1:0] hash_chal,
  input  logic              hash_done,
  input  logic [CODE_W-1:0] hash_code
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [1:0]                 rst_sync_q;
  logic                       rst_i_n;
  logic [ADDR_W-1:0]          slot_off;
  logic                       slot_hit;
  logic [IDX_W-1:0]           slot_idx;
  logic [NSLOT-1:0][DATA_W-1:0] slot_q;
  logic [NSLOT-1:0]           lock_q;
  logic                       slot_denied;
  logic [IDX_W-1:0]           fidx_q, sidx_q;
  logic [CODE_W-1:0]          res_q;
  logic                       err_q, nrdy_q, busy_q;
  logic [DATA_W-1:0]          rd_mux, rdata_q;

  // Reset asserts asynchronously and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign slot_off = bus_addr - A_SLOT0;
  assign slot_hit = (bus_addr >= A_SLOT0) && (slot_off < ADDR_W'(NSLOT));
  assign slot_idx = slot_off[IDX_W-1:0];

  auth_secret_store #(.NSLOT(NSLOT), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (bus_wr && slot_hit),
    .wr_idx    (slot_idx),
    .wr_data   (bus_wdata),
    .lock_en   (bus_wr && (bus_addr == A_LOCK)),
    .lock_bits (bus_wdata[NSLOT-1:0]),
    .slot_q    (slot_q),
    .lock_q    (lock_q),
    .wr_denied (slot_denied)
  );

  auth_seq_fsm #(.NSLOT(NSLOT), .DATA_W(DATA_W), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .sel_wr      (bus_wr && (bus_addr == A_SEL)),
    .sel_f       (bus_wdata[IDX_W-1:0]),
    .sel_s       (bus_wdata[2*IDX_W-1:IDX_W]),
    .chal_wr     (bus_wr && (bus_addr == A_CHAL)),
    .wdata       (bus_wdata),
    .res_rd      (bus_rd && (bus_addr == A_RES)),
    .stat_wr     (bus_wr && (bus_addr == A_STAT)),
    .slot_denied (slot_denied),
    .hash_done   (hash_done),
    .hash_code   (hash_code),
    .fidx_q      (fidx_q),
    .sidx_q      (sidx_q),
    .chal_q      (hash_chal),
    .res_q       (res_q),
    .err_q       (err_q),
    .nrdy_q      (nrdy_q),
    .busy_q      (busy_q),
    .load_q      (hash_load),
    .start_q     (hash_start)
  );

  // Secret routing to the engine ignores the lock bits on purpose.
  always_comb begin
    hash_func = '0;
    hash_seed = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (fidx_q == IDX_W'(i)) hash_func = slot_q[i];
      if (sidx_q == IDX_W'(i)) hash_seed = slot_q[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (slot_hit) begin
      for (int i = 0; i < NSLOT; i++)
        if ((slot_idx == IDX_W'(i)) && !lock_q[i]) rd_mux = slot_q[i];
    end else begin
      case (bus_addr)
        A_SEL:  rd_mux = DATA_W'({sidx_q, fidx_q});
        A_CHAL: rd_mux = hash_chal;
        A_RES:  rd_mux = DATA_W'(res_q);
        A_STAT: rd_mux = DATA_W'({busy_q, nrdy_q, err_q});
        A_LOCK: rd_mux = DATA_W'(lock_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/auth_seq_chk.sv
module auth_seq_chk
  import auth_seq_pkg::*;
#(
  parameter int NSLOT  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              wdata0,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              hash_load,
  input logic              hash_start,
  input logic [NSLOT-1:0]  lock_q,
  input logic              err_q
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [ADDR_W-1:0] off;
  logic              locked_rd;
  logic              armed_chk;

  always_comb begin
    off       = bus_addr - A_SLOT0;
    locked_rd = 1'b0;
    if (bus_rd && (bus_addr >= A_SLOT0) && (off < ADDR_W'(NSLOT)))
      locked_rd = lock_q[off[IDX_W-1:0]];
  end

  // Independent view of the sequence: a load arms, a start disarms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_chk <= 1'b0;
    else if (hash_load)  armed_chk <= 1'b1;
    else if (hash_start) armed_chk <= 1'b0;
  end

  AST_LOAD_FROM_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    hash_load |-> $past(bus_wr && (bus_addr == A_SEL))); // R2
  AST_START_FROM_CHAL: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |-> $past(bus_wr && (bus_addr == A_CHAL))); // R3
  AST_START_NEEDS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hash_start |-> armed_chk); // R4
  AST_ERR_CLEAR_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(bus_wr && (bus_addr == A_STAT) && wdata0)); // R7
  AST_LOCK_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & ~lock_q) == '0)); // R8
  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked_rd) |-> (bus_rdata == '0)); // R9
endmodule

bind auth_seq_ctrl auth_seq_chk #(.NSLOT(NSLOT), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .wdata0     (bus_wdata[0]),
  .bus_rdata  (bus_rdata),
  .hash_load  (hash_load),
  .hash_start (hash_start),
  .lock_q     (lock_q),
  .err_q      (err_q)
);

// File: tb/sim_auth_seq_ctrl.sv
module sim_auth_seq_ctrl;
  localparam int ENG_LAT = 8;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RC = 3'd2,
                         OP_ID = 3'd3, OP_ST = 3'd4, OP_LD = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 56;
  // RC: data = accepted challenge, exp[1:0] = function slot, exp[3:2] = seed slot.
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'h8, 32'hA5C31F07, 32'h0, 4'd9},        // R9 fill slots
    '{OP_WR, 4'h9, 32'h12345678, 32'h0, 4'd9},
    '{OP_WR, 4'hA, 32'hDEADBEEF, 32'h0, 4'd9},
    '{OP_RD, 4'h8, 32'h0, 32'hA5C31F07, 4'd9},        // R9 unlocked readback
    '{OP_WR, 4'h1, 32'h11111111, 32'h0, 4'd4},        // R4 challenge with no select
    '{OP_RD, 4'h3, 32'h0, 32'h1, 4'd4},
    '{OP_ST, 4'h0, 32'h0, 32'd0, 4'd4},
    '{OP_WR, 4'h3, 32'h0, 32'h0, 4'd7},               // R7 write 0 keeps flag
    '{OP_RD, 4'h3, 32'h0, 32'h1, 4'd7},
    '{OP_WR, 4'h3, 32'h1, 32'h0, 4'd7},
    '{OP_RD, 4'h3, 32'h0, 32'h0, 4'd7},
    '{OP_WR, 4'h0, 32'h8, 32'h0, 4'd2},               // R2 f=0 s=2
    '{OP_LD, 4'h0, 32'h0, 32'd1, 4'd2},
    '{OP_WR, 4'h1, 32'hCAFEF00D, 32'h0, 4'd3},        // R3
    '{OP_ST, 4'h0, 32'h0, 32'd1, 4'd3},
    '{OP_RD, 4'h2, 32'h0, 32'h0, 4'd6},               // R6 early read
    '{OP_RD, 4'h3, 32'h0, 32'h6, 4'd6},
    '{OP_ID, 4'h0, 32'd12, 32'h0, 4'd5},
    '{OP_RC, 4'h0, 32'hCAFEF00D, 32'h8, 4'd5},        // R5
    '{OP_RD, 4'h3, 32'h0, 32'h2, 4'd5},
    '{OP_WR, 4'h3, 32'h2, 32'h0, 4'd7},
    '{OP_RD, 4'h3, 32'h0, 32'h0, 4'd7},
    '{OP_WR, 4'h1, 32'h00000001, 32'h0, 4'd4},        // R4 no reselect
    '{OP_ST, 4'h0, 32'h0, 32'd1, 4'd4},
    '{OP_RD, 4'h3, 32'h0, 32'h1, 4'd4},
    '{OP_WR, 4'h3, 32'h1, 32'h0, 4'd7},
    '{OP_WR, 4'h0, 32'h5, 32'h0, 4'd2},               // R2 same slot twice
    '{OP_LD, 4'h0, 32'h0, 32'd2, 4'd2},
    '{OP_WR, 4'h1, 32'h0BADC0DE, 32'h0, 4'd3},
    '{OP_ST, 4'h0, 32'h0, 32'd2, 4'd3},
    '{OP_WR, 4'h0, 32'h0, 32'h0, 4'd12},              // R12 select while busy
    '{OP_LD, 4'h0, 32'h0, 32'd2, 4'd12},
    '{OP_RD, 4'h3, 32'h0, 32'h5, 4'd12},
    '{OP_ID, 4'h0, 32'd12, 32'h0, 4'd5},
    '{OP_RC, 4'h0, 32'h0BADC0DE, 32'h5, 4'd5},
    '{OP_WR, 4'h3, 32'h3, 32'h0, 4'd7},
    '{OP_WR, 4'h0, 32'h3, 32'h0, 4'd11},              // R11 index 3
    '{OP_LD, 4'h0, 32'h0, 32'd2, 4'd11},
    '{OP_RD, 4'h3, 32'h0, 32'h1, 4'd11},
    '{OP_RD, 4'h0, 32'h0, 32'h5, 4'd11},
    '{OP_WR, 4'h3, 32'h1, 32'h0, 4'd7},
    '{OP_WR, 4'h4, 32'h2, 32'h0, 4'd8},               // R8 lock slot 1
    '{OP_RD, 4'h4, 32'h0, 32'h2, 4'd8},
    '{OP_WR, 4'h4, 32'h0, 32'h0, 4'd8},
    '{OP_RD, 4'h4, 32'h0, 32'h2, 4'd8},
    '{OP_RD, 4'h9, 32'h0, 32'h0, 4'd9},               // R9 locked read
    '{OP_WR, 4'h9, 32'hFFFFFFFF, 32'h0, 4'd9},
    '{OP_RD, 4'h3, 32'h0, 32'h1, 4'd9},
    '{OP_WR, 4'h3, 32'h1, 32'h0, 4'd7},
    '{OP_WR, 4'h4, 32'h4, 32'h0, 4'd8},
    '{OP_RD, 4'h4, 32'h0, 32'h6, 4'd8},
    '{OP_WR, 4'h0, 32'h1, 32'h0, 4'd10},              // R10 locked slot as function
    '{OP_LD, 4'h0, 32'h0, 32'd3, 4'd10},
    '{OP_WR, 4'h1, 32'h5A5A5A5A, 32'h0, 4'd10},
    '{OP_ID, 4'h0, 32'd12, 32'h0, 4'd10},
    '{OP_RC, 4'h0, 32'h5A5A5A5A, 32'h1, 4'd10}
  };

  logic        clk, rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd;
  logic        hash_load, hash_start, hash_done;
  logic [31:0] hash_func, hash_seed, hash_chal;
  logic [7:0]  hash_code;

  int checks, fails, nload, nstart;
  bit finished;
  logic [31:0] sec_sh [3];
  logic [2:0]  lock_sh;

  auth_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hash_load(hash_load), .hash_func(hash_func), .hash_seed(hash_seed),
    .hash_start(hash_start), .hash_chal(hash_chal),
    .hash_done(hash_done), .hash_code(hash_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] code_of(logic [31:0] f, logic [31:0] s, logic [31:0] c);
    logic [31:0] m;
    m = f ^ {s[15:0], s[31:16]} ^ c;
    return m[7:0] ^ m[15:8] ^ m[23:16] ^ m[31:24] ^ 8'h5C;
  endfunction

  // Engine model: fixed latency from start to done.
  logic [31:0] ef, es, ec;
  int ecnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_done <= 1'b0; hash_code <= 8'h0; ecnt <= 0;
      ef <= '0; es <= '0; ec <= '0;
    end else begin
      hash_done <= 1'b0;
      if (hash_load) begin ef <= hash_func; es <= hash_seed; end
      if (hash_start) begin ec <= hash_chal; ecnt <= ENG_LAT; end
      else if (ecnt != 0) begin
        ecnt <= ecnt - 1;
        if (ecnt == 1) begin hash_done <= 1'b1; hash_code <= code_of(ef, es, ec); end
      end
    end
  end

  always @(posedge clk) begin
    if (hash_load)  nload  <= nload + 1;
    if (hash_start) nstart <= nstart + 1;
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    checks = 0; fails = 0; nload = 0; nstart = 0; finished = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    lock_sh = '0;
    for (int i = 0; i < 3; i++) sec_sh[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(1, {31'd0, hash_load},  32'd0, "hash_load after reset");
    check(1, {31'd0, hash_start}, 32'd0, "hash_start after reset");
    do_rd(4'h3, d); check(1, d, 32'h0, "status after reset");
    do_rd(4'h2, d); check(1, d, 32'h0, "result after reset");
    do_rd(4'h4, d); check(1, d, 32'h0, "locks after reset");
    do_rd(4'h0, d); check(1, d, 32'h0, "selection after reset");

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VECS[v];
      case (e.op)
        OP_WR: begin
          if (e.addr >= 4'h8 && e.addr <= 4'hA && !lock_sh[e.addr - 4'h8])
            sec_sh[e.addr - 4'h8] = e.data;
          if (e.addr == 4'h4) lock_sh = lock_sh | e.data[2:0];
          do_wr(e.addr, e.data);
        end
        OP_RD: begin
          do_rd(e.addr, d);
          check(int'(e.req), d, e.exp, $sformatf("read addr %h (vec %0d)", e.addr, v));
        end
        OP_RC: begin
          do_rd(4'h2, d);
          check(int'(e.req), d,
                {24'd0, code_of(sec_sh[e.exp[1:0]], sec_sh[e.exp[3:2]], e.data)},
                $sformatf("result code (vec %0d)", v));
        end
        OP_ID: repeat (e.data) @(negedge clk);
        OP_ST: begin
          @(negedge clk);
          check(int'(e.req), nstart, e.exp, $sformatf("hash_start count (vec %0d)", v));
        end
        OP_LD: begin
          @(negedge clk);
          check(int'(e.req), nload, e.exp, $sformatf("hash_load count (vec %0d)", v));
        end
        default: ;
      endcase
    end

    // R1 directed: reset clears locks and flags again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_rd(4'h4, d); check(1, d, 32'h0, "locks after second reset");
    do_rd(4'h3, d); check(1, d, 32'h0, "status after second reset");

    finish_run();
  end
endmodule